// File: doc/BRIEF.md
# Address Security Attribution Unit

This unit sits beside a processor's memory port and classifies each 32-bit physical address it is given. For every accepted address it reports which 256 MB region the address falls in, whether that region is secure or non-secure, whether it is a secure region that software has opened for non-secure entry calls, and whether it lies in one of the two system windows that skip security checks. Attribution comes only from address bits and one small configuration register, so no table is involved.

The same lookup also produces a folded address for the downstream decoder. Three upper windows are secure aliases of the window just below them, and the unit clears bit 28 so the decoder sees the backing address. A few control pages live only in the upper peripheral window. They are left at their own address and flagged so the decoder can route them.

Lookups travel on a valid/ready stream with one register stage. A lookup is accepted on any rising edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle and stays frozen while `out_ready` is low. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. That lets an unstalled stream take one new address on every cycle. The configuration register is written through a plain write strobe, offset and data.

Top module: `addr_attr_unit`

## Requirements
- R1: `out_region` equals bits [31:28] of the accepted address.
- R2: `out_nonsec` is 1 when bit 28 of the accepted address is 0, and 0 when it is 1.
- R3: `out_nsc` is 1 for region 1 only when configuration bit 0 is 1, and for region 3 only when configuration bit 1 is 1. It is 0 for every other region.
- R4: `out_exempt` is 1 exactly when (address AND 0xEFF00000) equals 0xE0000000. So 0xE00FFFFF and 0xF00FFFFF are exempt, while 0xE0100000 and 0xDFFFFFFF are not.
- R5: For regions 1, 3 and 5, `out_addr` is the accepted address with bit 28 cleared. For every other region it is the accepted address unchanged.
- R6: These 4 KB pages exist only in region 5: 0x50080000, 0x50021000, 0x5002E000, 0x50081000 and 0x50083000. For any of them, `out_upper_only` is 1 and `out_addr` is not folded. It is 0 for every other address, including 0x50082000.
- R7: The configuration register resets to 0 and sits at offset 0. A write stores `cfg_wdata[1:0]`, and bits [31:2] always read as 0. A write to any other offset changes nothing. `cfg_rdata` shows the register when `cfg_addr` is 0 and reads 0 otherwise.
- R8: A lookup accepted on the same edge as a configuration write uses the old value. A lookup accepted on the next edge or later uses the new value.
- R9: `out_valid` rises on the cycle after an accepted lookup. `in_ready` equals (not `out_valid`) or `out_ready`, so an unstalled stream is accepted on every cycle and results come out in order.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field keeps its value on the next cycle, even if a configuration write happens.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Unit can accept a lookup |
| in_addr | input | 32 | Physical address to classify |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_region | output | 4 | Region number (address bits 31:28) |
| out_nonsec | output | 1 | Address is non-secure |
| out_nsc | output | 1 | Secure region open for non-secure entry |
| out_exempt | output | 1 | Address is in a check-exempt system window |
| out_upper_only | output | 1 | Address hits a page that exists only in the upper window |
| out_addr | output | 32 | Folded address for the downstream decoder |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |

## Verification
Every lookup result is due exactly one cycle after the edge that accepts the address. That delay is longer only when the output stage was stalled, and then the result waits until it is taken. The driver predicts each result when it sees the accept condition just before the edge, taking the configuration value the register held before that edge, and puts the prediction in a queue. The monitor samples outputs mid-cycle and compares against the head of the queue only on cycles where a transfer will occur, so a stall simply postpones the comparison, and it separately checks that stalled outputs stay frozen. Configuration reads are combinational and are checked in the same half-cycle in which the offset is driven. Write effects are checked from the cycle after the write edge.

// File: rtl/addr_attr_pkg.sv
package addr_attr_pkg;
  localparam int ADDR_W   = 32;
  localparam int REGION_W = 4;
  localparam int REGION_LSB = ADDR_W - REGION_W;

  typedef struct packed {
    logic [REGION_W-1:0] region;
    logic                nonsec;
    logic                nsc;
    logic                exempt;
    logic                upper_only;
    logic [ADDR_W-1:0]   addr;
  } attr_t;
endpackage

// File: rtl/attr_cfg_reg.sv
module attr_cfg_reg #(
  parameter int CFG_AW  = 4,
  parameter int CFG_OFF = 0,
  parameter int NSC_W   = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NSC_W-1:0]  cfg
);
  localparam logic [DATA_W-1:0] WR_MASK = {{(DATA_W-NSC_W){1'b0}}, {NSC_W{1'b1}}};
  localparam logic [CFG_AW-1:0] OFF     = CFG_OFF[CFG_AW-1:0];

  logic [DATA_W-1:0] cfg_q;
  logic              hit;

  assign hit = (addr == OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (we && hit) cfg_q <= wdata & WR_MASK;
  end

  assign cfg   = cfg_q[NSC_W-1:0];
  assign rdata = hit ? cfg_q : '0;

  // R7: a write at the matching offset is visible the following cycle
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit) |=> (cfg == $past(wdata[NSC_W-1:0])));
  // R7: a write elsewhere leaves the register unchanged
  a_r7_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> $stable(cfg));
endmodule

// File: rtl/attr_classify.sv
module attr_classify
  import addr_attr_pkg::*;
#(
  parameter int               NSC_W        = 2,
  parameter logic [ADDR_W-1:0] EXEMPT_MASK  = 32'hEFF0_0000,
  parameter logic [ADDR_W-1:0] EXEMPT_MATCH = 32'hE000_0000
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NSC_W-1:0]    cfg,
  output logic [REGION_W-1:0] region,
  output logic                nonsec,
  output logic                nsc,
  output logic                exempt
);
  logic [NSC_W-1:0] nsc_hit;

  assign region = addr[ADDR_W-1:REGION_LSB];
  assign nonsec = ~addr[REGION_LSB];
  assign exempt = ((addr & EXEMPT_MASK) == EXEMPT_MATCH);

  // configuration bit i opens secure region 2*i+1
  for (genvar i = 0; i < NSC_W; i++) begin : g_nsc
    localparam logic [REGION_W-1:0] NSC_REGION = REGION_W'(2 * i + 1);
    assign nsc_hit[i] = cfg[i] && (region == NSC_REGION);
  end

  assign nsc = |nsc_hit;
endmodule

// File: rtl/attr_window_map.sv
module attr_window_map
  import addr_attr_pkg::*;
#(
  parameter int                 PAGE_BITS  = 12,
  parameter int                 NUM_PAGES  = 5,
  parameter logic [15:0]        ALIAS_MASK = 16'b0000_0000_0010_1010,
  parameter logic [NUM_PAGES*(ADDR_W-PAGE_BITS)-1:0] PAGE_LIST =
    {20'h50083, 20'h50081, 20'h5002E, 20'h50021, 20'h50080}
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              upper_only
);
  localparam int PN_W = ADDR_W - PAGE_BITS;

  logic [NUM_PAGES-1:0] page_hit;
  logic                 alias_win;
  logic [PN_W-1:0]      page_num;

  assign page_num = addr_in[ADDR_W-1:PAGE_BITS];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign page_hit[p] = (page_num == PAGE_LIST[p*PN_W +: PN_W]);
  end

  assign upper_only = |page_hit;
  assign alias_win  = ALIAS_MASK[addr_in[ADDR_W-1:REGION_LSB]];

  always_comb begin
    addr_out = addr_in;
    if (alias_win && !upper_only) addr_out[REGION_LSB] = 1'b0;
  end
endmodule

// File: rtl/addr_attr_unit.sv
module addr_attr_unit
  import addr_attr_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int NSC_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ADDR_W-1:0]   in_addr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [REGION_W-1:0] out_region,
  output logic                out_nonsec,
  output logic                out_nsc,
  output logic                out_exempt,
  output logic                out_upper_only,
  output logic [ADDR_W-1:0]   out_addr,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata
);
  logic [NSC_W-1:0] nsc_cfg;
  attr_t            lookup_d;
  attr_t            lookup_q;
  logic             valid_q;

  attr_cfg_reg #(.CFG_AW(CFG_AW), .CFG_OFF(0), .NSC_W(NSC_W), .DATA_W(32)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(nsc_cfg)
  );

  attr_classify #(.NSC_W(NSC_W)) u_classify (
    .addr(in_addr), .cfg(nsc_cfg), .region(lookup_d.region),
    .nonsec(lookup_d.nonsec), .nsc(lookup_d.nsc), .exempt(lookup_d.exempt)
  );

  attr_window_map u_map (
    .addr_in(in_addr), .addr_out(lookup_d.addr), .upper_only(lookup_d.upper_only)
  );

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      lookup_q <= '0;
    end else if (in_ready) begin
      valid_q  <= in_valid;
      if (in_valid) lookup_q <= lookup_d;
    end
  end

  assign out_valid      = valid_q;
  assign out_region     = lookup_q.region;
  assign out_nonsec     = lookup_q.nonsec;
  assign out_nsc        = lookup_q.nsc;
  assign out_exempt     = lookup_q.exempt;
  assign out_upper_only = lookup_q.upper_only;
  assign out_addr       = lookup_q.addr;

  // R9: an accepted lookup is presented on the next cycle
  a_r9_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R10: a stalled result is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_region)
      && $stable(out_nsc) && $stable(out_nonsec) && $stable(out_exempt)
      && $stable(out_upper_only)));
  // R3: entry-callable only ever reported for a secure region
  a_r3_nsc_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nsc) |-> !out_nonsec);
  // R6: upper-only pages belong to region 5 and stay unfolded
  a_r6_upper_unfolded: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_upper_only) |-> (out_region == 4'd5 && out_addr[28]));
  // R5: folding touches only bit 28
  a_r5_fold_bits: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[31:29] == out_region[3:1]));
  // R11: no result without a prior accept right after reset
  a_r11_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);
endmodule

// File: tb/addr_attr_unit_tb.sv
`timescale 1ns/1ps
module addr_attr_unit_tb;
  import addr_attr_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] in_addr = '0, out_addr;
  logic [3:0] out_region;
  logic out_nonsec, out_nsc, out_exempt, out_upper_only;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;

  int checks = 0, errors = 0;
  logic [1:0] model_cfg = 2'b00;
  logic bp = 1'b0;
  attr_t exp_q[$];

  always #2 clk = ~clk;

  addr_attr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_region(out_region),
    .out_nonsec(out_nonsec), .out_nsc(out_nsc), .out_exempt(out_exempt),
    .out_upper_only(out_upper_only), .out_addr(out_addr),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic attr_t ref_attr(input logic [31:0] a, input logic [1:0] c);
    attr_t r;
    logic [3:0] rg = a[31:28];
    logic up;
    up = (a[31:12] == 20'h50080) || (a[31:12] == 20'h50021) || (a[31:12] == 20'h5002E)
      || (a[31:12] == 20'h50081) || (a[31:12] == 20'h50083);
    r.region     = rg;
    r.nonsec     = (a[28] == 1'b0);
    r.nsc        = (rg == 4'd1 && c[0]) || (rg == 4'd3 && c[1]);
    r.exempt     = ((a & 32'hEFF0_0000) == 32'hE000_0000);
    r.upper_only = up;
    r.addr       = ((rg == 4'd1 || rg == 4'd3 || rg == 4'd5) && !up) ? (a & ~32'h1000_0000) : a;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: present one address, push the prediction when the accept is certain
  task automatic issue(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(ref_attr(a, model_cfg));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg_wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 4'd0;
    if (off == 4'd0) model_cfg = d[1:0];
  endtask

  task automatic cfg_rd(input logic [3:0] off, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = off;
    #1;
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
    cfg_addr = 4'd0;
  endtask

  task automatic drain();
    idle();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results delivered", 32'(exp_q.size()), 32'd0);
  endtask

  // consumer ready pattern
  initial begin
    int rc = 0;
    forever begin
      @(negedge clk);
      rc++;
      out_ready = bp ? ((rc % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    attr_t held, e;
    bit stalled = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (stalled) begin
          chk(out_valid && out_addr == held.addr && out_region == held.region
              && out_nsc == held.nsc && out_nonsec == held.nonsec && out_exempt == held.exempt
              && out_upper_only == held.upper_only, "R10 stalled output held", out_addr, held.addr);
        end
        stalled = 1'b0;
        if (out_valid && !out_ready) begin
          stalled = 1'b1;
          held = '{out_region, out_nonsec, out_nsc, out_exempt, out_upper_only, out_addr};
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected result", out_addr, 32'd0);
          end else begin
            e = exp_q.pop_front();
            chk(out_region == e.region, "R1 region", 32'(out_region), 32'(e.region));
            chk(out_nonsec == e.nonsec, "R2 nonsec", 32'(out_nonsec), 32'(e.nonsec));
            chk(out_nsc == e.nsc, "R3 nsc", 32'(out_nsc), 32'(e.nsc));
            chk(out_exempt == e.exempt, "R4 exempt", 32'(out_exempt), 32'(e.exempt));
            chk(out_addr == e.addr, "R5 folded address", out_addr, e.addr);
            chk(out_upper_only == e.upper_only, "R6 upper-only flag",
                32'(out_upper_only), 32'(e.upper_only));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf = 32'hACE1_2345;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", 32'(in_ready), 32'd1);
    chk(cfg_rdata == 32'd0, "R7 register reset value", cfg_rdata, 32'd0);

    // R7: register access rules
    cfg_wr(4'd0, 32'hFFFF_FFFF);
    cfg_rd(4'd0, 32'h0000_0003, "R7 upper bits read zero");
    cfg_wr(4'd5, 32'h0000_0000);
    cfg_rd(4'd0, 32'h0000_0003, "R7 write at other offset ignored");
    cfg_rd(4'd5, 32'h0000_0000, "R7 other offset reads zero");
    cfg_wr(4'd0, 32'h0000_0000);
    cfg_rd(4'd0, 32'h0000_0000, "R7 register cleared");

    // R9: exact one-cycle latency
    issue(32'h2000_0040);
    idle();
    #1;
    chk(out_valid == 1'b1, "R9 valid one cycle after accept", 32'(out_valid), 32'd1);
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R9 valid drops when idle", 32'(out_valid), 32'd0);

    // R1 R2 R3 R5: every region under every configuration
    for (int c = 0; c < 4; c++) begin
      cfg_wr(4'd0, 32'(c));
      for (int r = 0; r < 16; r++) begin
        issue({4'(r), 28'h0123_4560});
        issue({4'(r), 28'hFFF_FFFC});
      end
      idle();
    end

    // R4: exempt window edges
    cfg_wr(4'd0, 32'd3);
    issue(32'hE000_0000); issue(32'hE00F_FFFF); issue(32'hE010_0000);
    issue(32'hDFFF_FFFF); issue(32'hF000_0000); issue(32'hF00F_FFFF);
    issue(32'hF010_0000); issue(32'hEFF0_0000);

    // R6: upper-only pages and neighbours
    issue(32'h5008_0000); issue(32'h5002_1004); issue(32'h5002_EFFC);
    issue(32'h5008_1800); issue(32'h5008_3010); issue(32'h5008_2000);
    issue(32'h5007_F000); issue(32'h4008_0000); issue(32'h5002_0FFC);
    drain();

    // R8: write and lookup on the same edge, then the next edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'd0;
    in_valid = 1'b1; in_addr = 32'h1000_0100;
    #1;
    exp_q.push_back(ref_attr(32'h1000_0100, model_cfg));  // old value (3)
    @(negedge clk);
    cfg_we = 1'b0; model_cfg = 2'b00;
    in_addr = 32'h3000_0200;
    #1;
    exp_q.push_back(ref_attr(32'h3000_0200, model_cfg));  // new value
    drain();

    // R9 R10: stream under back-pressure, with configuration writes while stalled
    bp = 1'b1;
    for (int k = 0; k < 150; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(lf);
    end
    idle();
    repeat (4) @(negedge clk);
    cfg_wr(4'd0, 32'd1);
    for (int k = 0; k < 100; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue({lf[31:29], 1'b1, lf[27:0]});
    end
    drain();
    bp = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule